// File: doc/BRIEF.md
# Eight-Input Fixed-Priority Vectored Interrupt Controller

The controller collects level-sensitive interrupt requests from eight input pins and raises one interrupt line toward a processor. Each input is sampled into an internal request register that no port can read or write. A mask register that software can read and write gates each input. Priority is fixed by index: input 0 beats input 1, and so on down to input 7. An in-service register records which requests are being handled. A pending request raises the interrupt line only when it is unmasked and outranks every bit already in service. Higher-priority sources can therefore nest on top of lower ones.

When the processor pulses the acknowledge input, the controller grants the best eligible request and sets its in-service bit. In the next cycle it presents an 8-bit vector for one cycle. The vector carries a 5-bit programmable base in its upper bits and the granted index in its lower three bits. Software ends an interrupt either by a non-specific end-of-interrupt command, which clears the highest-priority in-service bit, or by selecting automatic mode, where the controller clears the bit itself during the vector cycle.

Because inputs are level-sensitive, a source that is still asserted when its in-service bit clears requests again with the same vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the interrupt line and vector_valid are low. The mask reads 0xFF, the base reads 0x00, the mode register reads 0x00 and nothing is in service.
- R2: Register address 1 is the mask, readable and writable. Mask bit i set means input i can never raise the interrupt line.
- R3: Request pins are sampled at each clock edge. The interrupt line is high exactly when some sampled, unmasked request has a lower index than every in-service bit.
- R4: When inta is high while the interrupt line is high, the lowest-index eligible request is granted and its in-service bit is set. While that bit stays set, requests of equal or higher index do not raise the interrupt line, and the line is low in the vector cycle.
- R5: A write to address 2 with data bit 0 set clears the lowest-index in-service bit and no other.
- R6: In the cycle after a grant, vector_valid is high for one cycle and vector_out equals {base[7:3], granted index}. Address 0 holds the base, and its low three bits read as 0. vector_out is 0 whenever vector_valid is low.
- R7: Address 3 bit 0 selects automatic end-of-interrupt. In that mode the granted in-service bit is cleared at the end of the vector cycle without any command.
- R8: A request still asserted after its in-service bit clears raises the interrupt line again and yields the same vector on the next acknowledge.
- R9: An acknowledge while the interrupt line is low produces no vector_valid and leaves the in-service state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level-sensitive request pins, index 0 highest |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 base, 1 mask, 2 command, 3 mode |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register; the command address reads 0 |
| intr | output | 1 | Interrupt line to the processor |
| inta | input | 1 | Single-cycle acknowledge pulse |
| vector_out | output | 8 | Vector of the granted request |
| vector_valid | output | 1 | Vector qualifier, high for one cycle after a grant |

## Verification
Some properties are checked on every cycle. A vector only ever follows an acknowledge and lasts one cycle. The granted bit is in service while its vector is shown, and the interrupt line is low at that time. The vector's upper bits match the base held at grant time. The output is zero outside the vector cycle. A fully masked controller never interrupts, and an end-of-interrupt command removes exactly one in-service bit. Other behaviours need stimulus sequences from the bench scenarios: the choice among competing requests, nesting of a higher source over a lower one, blocking of equal and lower sources, re-requests from held levels after an end-of-interrupt, automatic-mode clearing, and acknowledges without a request.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    RA_BASE = 2'd0,
    RA_MASK = 2'd1,
    RA_CMD  = 2'd2,
    RA_MODE = 2'd3
  } reg_addr_e;

  localparam int unsigned REG_DW   = 8;
  localparam int unsigned CMD_EOI  = 0;
  localparam int unsigned MODE_AUTO = 0;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W  = $clog2(N_IRQ),
  localparam int unsigned BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic [BASE_W-1:0] base_hi,
  output logic [N_IRQ-1:0]  mask,
  output logic              auto_eoi,
  output logic              eoi_cmd
);
  logic [BASE_W-1:0] base_q, base_d;
  logic [N_IRQ-1:0]  mask_q, mask_d;
  logic              auto_q, auto_d;
  logic              we_base, we_mask, we_mode;

  always_comb begin
    we_base = wr_en && (addr == RA_BASE);
    we_mask = wr_en && (addr == RA_MASK);
    we_mode = wr_en && (addr == RA_MODE);
    eoi_cmd = wr_en && (addr == RA_CMD) && wdata[CMD_EOI];
    base_d  = we_base ? wdata[VEC_W-1:IDX_W] : base_q;
    mask_d  = we_mask ? wdata[N_IRQ-1:0]     : mask_q;
    auto_d  = we_mode ? wdata[MODE_AUTO]     : auto_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '1;
      auto_q <= 1'b0;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
      auto_q <= auto_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      RA_BASE: rdata[VEC_W-1:0] = {base_q, {IDX_W{1'b0}}};
      RA_MASK: rdata[N_IRQ-1:0] = mask_q;
      RA_CMD:  rdata = '0;
      RA_MODE: rdata[MODE_AUTO] = auto_q;
      default: rdata = '0;
    endcase
  end

  assign base_hi  = base_q;
  assign mask     = mask_q;
  assign auto_eoi = auto_q;
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned IDX_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] irr,
  input  logic [N_IRQ-1:0] mask,
  input  logic [N_IRQ-1:0] isr,
  output logic             intr,
  output logic [N_IRQ-1:0] grant_oh,
  output logic [IDX_W-1:0] grant_idx,
  output logic [N_IRQ-1:0] isr_top_oh
);
  logic [N_IRQ-1:0] pend;
  logic [N_IRQ-1:0] elig;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_lane
    logic blocked;
    assign blocked = |isr[i:0];
    assign pend[i] = irr[i] & ~mask[i];
    assign elig[i] = pend[i] & ~blocked;
  end

  assign grant_oh   = elig & (~elig + 1'b1);
  assign isr_top_oh = isr & (~isr + 1'b1);
  assign intr       = |elig;

  always_comb begin
    grant_idx = '0;
    for (int k = 0; k < N_IRQ; k++) begin
      if (grant_oh[k]) grant_idx = grant_idx | IDX_W'(k);
    end
  end
endmodule

// File: rtl/irq_service.sv
module irq_service #(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W  = $clog2(N_IRQ),
  localparam int unsigned BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta,
  input  logic              intr,
  input  logic [N_IRQ-1:0]  grant_oh,
  input  logic [IDX_W-1:0]  grant_idx,
  input  logic [N_IRQ-1:0]  isr_top_oh,
  input  logic              eoi_cmd,
  input  logic              auto_eoi,
  input  logic [BASE_W-1:0] base_hi,
  output logic [N_IRQ-1:0]  isr,
  output logic [VEC_W-1:0]  vector_out,
  output logic              vector_valid
);
  logic [N_IRQ-1:0] isr_q, isr_d;
  logic [N_IRQ-1:0] last_q, last_d;
  logic [N_IRQ-1:0] clr;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vv_q, vv_d;
  logic             take;

  always_comb begin
    take   = inta & intr;
    clr    = (eoi_cmd ? isr_top_oh : '0) | ((vv_q & auto_eoi) ? last_q : '0);
    isr_d  = (isr_q & ~clr) | (take ? grant_oh : '0);
    vv_d   = take;
    vec_d  = {base_hi, grant_idx};
    last_d = grant_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      vv_q   <= 1'b0;
      vec_q  <= '0;
      last_q <= '0;
    end else begin
      isr_q <= isr_d;
      vv_q  <= vv_d;
      if (take) begin
        vec_q  <= vec_d;
        last_q <= last_d;
      end
    end
  end

  assign isr          = isr_q;
  assign vector_valid = vv_q;
  assign vector_out   = vv_q ? vec_q : '0;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              intr,
  input  logic              inta,
  output logic [VEC_W-1:0]  vector_out,
  output logic              vector_valid
);
  localparam int unsigned IDX_W  = $clog2(N_IRQ);
  localparam int unsigned BASE_W = VEC_W - IDX_W;

  logic [N_IRQ-1:0]  irr_q;
  logic [N_IRQ-1:0]  mask_q;
  logic [N_IRQ-1:0]  isr_q;
  logic [N_IRQ-1:0]  grant_oh, isr_top_oh;
  logic [IDX_W-1:0]  grant_idx;
  logic [BASE_W-1:0] base_hi;
  logic              auto_eoi, eoi_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= irq_req;
  end

  irq_cfg_regs #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .base_hi(base_hi),
    .mask(mask_q), .auto_eoi(auto_eoi), .eoi_cmd(eoi_cmd)
  );

  irq_prio_resolve #(.N_IRQ(N_IRQ)) u_resolve (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .intr(intr),
    .grant_oh(grant_oh), .grant_idx(grant_idx), .isr_top_oh(isr_top_oh)
  );

  irq_service #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_service (
    .clk(clk), .rst_n(rst_n), .inta(inta), .intr(intr),
    .grant_oh(grant_oh), .grant_idx(grant_idx), .isr_top_oh(isr_top_oh),
    .eoi_cmd(eoi_cmd), .auto_eoi(auto_eoi), .base_hi(base_hi),
    .isr(isr_q), .vector_out(vector_out), .vector_valid(vector_valid)
  );
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W  = $clog2(N_IRQ),
  localparam int unsigned BASE_W = VEC_W - IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              intr,
  input logic              inta,
  input logic              vector_valid,
  input logic [VEC_W-1:0]  vector_out,
  input logic [N_IRQ-1:0]  isr,
  input logic [N_IRQ-1:0]  mask,
  input logic [BASE_W-1:0] base_hi,
  input logic              eoi_cmd
);
  assert_valid_follows_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |-> $past(inta));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |=> !vector_valid);

  assert_vec_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |-> vector_out[VEC_W-1:IDX_W] == $past(base_hi));

  assert_vec_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vector_valid |-> vector_out == '0);

  assert_granted_in_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |-> isr[vector_out[IDX_W-1:0]]);

  assert_intr_low_on_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |-> !intr);

  assert_all_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !intr);

  assert_eoi_clears_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && (isr != '0) && !inta && !vector_valid) |=>
      $countones(isr) == $past($countones(isr)) - 1);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .intr(intr), .inta(inta),
  .vector_valid(vector_valid), .vector_out(vector_out), .isr(isr_q),
  .mask(mask_q), .base_hi(base_hi), .eoi_cmd(eoi_cmd)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       intr;
  logic       inta = 1'b0;
  logic [7:0] vector_out;
  logic       vector_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .intr(intr), .inta(inta), .vector_out(vector_out), .vector_valid(vector_valid)
  );

  // behavioural reference state
  int m_irr, m_mask, m_base, m_auto, m_isr, m_vv, m_vec, m_last;

  function automatic int best();
    for (int i = 0; i < 8; i++) begin
      if ((m_isr >> i) & 1) return -1;
      if (((m_irr & ~m_mask) >> i) & 1) return i;
    end
    return -1;
  endfunction

  function automatic int exp_rdata(int a);
    case (a)
      0: return m_base;
      1: return m_mask;
      3: return m_auto;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irr = 0; m_mask = 8'hFF; m_base = 0; m_auto = 0;
      m_isr = 0; m_vv = 0; m_vec = 0; m_last = 0;
    end else begin
      int g;
      int nisr;
      g = best();
      nisr = m_isr;
      if (reg_wr && reg_addr == 2 && reg_wdata[0]) begin
        for (int i = 0; i < 8; i++)
          if ((m_isr >> i) & 1) begin nisr = nisr & ~(1 << i); break; end
      end
      if (m_vv && m_auto) nisr = nisr & ~(1 << m_last);
      if (inta && g >= 0) begin
        nisr = nisr | (1 << g);
        m_vv = 1; m_vec = (m_base & 8'hF8) | g; m_last = g;
      end else m_vv = 0;
      m_isr = nisr;
      if (reg_wr && reg_addr == 0) m_base = reg_wdata & 8'hF8;
      if (reg_wr && reg_addr == 1) m_mask = reg_wdata;
      if (reg_wr && reg_addr == 3) m_auto = reg_wdata & 1;
      m_irr = irq_req;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 intr vs model", intr, best() >= 0);
      chk("R6 vector_valid vs model", vector_valid, m_vv);
      chk("R6 vector_out vs model", vector_out, m_vv ? m_vec : 0);
      chk("R2 reg_rdata vs model", reg_rdata, exp_rdata(reg_addr));
    end
  end

  task automatic nx();
    @(negedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    nx();
    reg_wr = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    reg_addr = a[1:0];
    #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic ack();
    inta = 1;
    nx();
    inta = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    nx(); nx();
    // R1 reset state
    chk("R1 intr in reset", intr, 0);
    chk("R1 vector_valid in reset", vector_valid, 0);
    rd(1, 8'hFF, "R1 mask after reset");
    rd(0, 8'h00, "R1 base after reset");
    rd(3, 8'h00, "R1 mode after reset");
    rst_n = 1;
    nx();
    // R1 all masked: request has no effect
    irq_req = 8'h01; nx(); nx();
    chk("R1 masked by default", intr, 0);
    irq_req = 0;
    // R6 base register, low bits read zero
    wr(0, 8'hD5);
    rd(0, 8'hD0, "R6 base low bits zero");
    // R2 mask read/write
    wr(1, 8'hF0);
    rd(1, 8'hF0, "R2 mask readback");
    wr(1, 8'h00);
    // R3 single request
    irq_req = 8'h08; nx();
    chk("R3 intr on pin3", intr, 1);
    ack();
    chk("R6 vector pin3", vector_out, 8'hD3);
    chk("R6 valid pin3", vector_valid, 1);
    chk("R4 intr low in vector cycle", intr, 0);
    nx();
    chk("R6 valid one cycle", vector_valid, 0);
    chk("R6 vector zero when idle", vector_out, 0);
    // R4 lower priority blocked
    irq_req = 8'h28; nx(); nx();
    chk("R4 pin5 blocked by pin3", intr, 0);
    // R3 nesting by higher priority
    irq_req = 8'h2A; nx();
    chk("R3 pin1 nests over pin3", intr, 1);
    ack();
    chk("R6 vector pin1", vector_out, 8'hD1);
    nx();
    // R9 acknowledge with no request
    ack();
    chk("R9 no vector without intr", vector_valid, 0);
    // R5 EOI clears only pin1
    irq_req = 8'h28; nx();
    wr(2, 8'h01); nx();
    chk("R5 pin3 still blocks after one EOI", intr, 0);
    // R8 second EOI: pin3 still asserted re-requests
    wr(2, 8'h01);
    chk("R8 pin3 re-request after EOI", intr, 1);
    ack();
    chk("R8 same vector pin3", vector_out, 8'hD3);
    nx();
    irq_req = 0;
    wr(2, 8'h01); wr(2, 8'h00); nx();
    chk("R5 command bit0 clear ignored", intr, 0);
    wr(2, 8'h01); nx();
    // R2 masked input ignored
    wr(1, 8'h04);
    irq_req = 8'h04; nx(); nx();
    chk("R2 masked pin2 no intr", intr, 0);
    irq_req = 8'h06; nx();
    chk("R2 unmasked pin1 raises intr", intr, 1);
    ack(); chk("R6 vector pin1 under mask", vector_out, 8'hD1);
    irq_req = 0; nx(); wr(2, 8'h01); nx();
    // R7 automatic EOI
    wr(1, 8'h00); wr(3, 8'h01);
    rd(3, 8'h01, "R7 mode readback");
    wr(0, 8'h40);
    irq_req = 8'h40; nx();
    chk("R7 intr pin6", intr, 1);
    ack();
    chk("R7 vector pin6", vector_out, 8'h46);
    chk("R7 intr low during vector", intr, 0);
    nx();
    chk("R7 auto clear re-raises held pin6", intr, 1);
    irq_req = 8'h80; nx();
    chk("R7 nothing left in service, pin7 wins", intr, 1);
    ack(); chk("R7 vector pin7", vector_out, 8'h47);
    irq_req = 0; nx(); nx();
    chk("R7 idle after auto clear", intr, 0);
    nx();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule